// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery loop is running at the right frequency. It counts cycles of the recovered high-speed clock across a fixed number of rising edges of a slower reference clock. The reference runs at one sixteenth of the nominal recovered rate, so a window of N reference edges should hold N×16 recovered cycles. The block brings the reference into the recovered-clock domain through a two-flop synchronizer, and it evaluates the count error once at the close of each window.

The lock flag has asymmetric hysteresis. A wide error bound, about 2000 ppm of the window count, drops lock. A tight bound, about 500 ppm, is needed to regain it. Between the two bounds the flag keeps its value. The lock flag also steers a detector-select output. High selects phase tracking and low selects frequency acquisition. A settling filter between lock and select makes the loop change detectors only after lock has kept a new value for several windows in a row. An acquisition-only input pins select low, so that the loop stays on frequency detection and the block serves as a plain lock monitor. If the reference stops, a watchdog on the gap between reference edges forces lock low.

With the default parameters, a window is 16384 reference edges, the expected count is 262144, lock drops when the error exceeds 524 counts, and lock returns when the error is 131 counts or less. This tolerates a reference that is itself up to ±100 ppm off.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `lock_o` and `sel_o` are driven to 0 after that edge.
- R2: A measurement window spans WIN_REFS synchronized reference rising edges. It counts recovered cycles from one boundary edge to the next, against an expected count of WIN_REFS×RATIO. After reset or a timeout, the first reference edge only opens a window and produces no verdict.
- R3: At a window close, an absolute count error greater than DROP_ERR drives `lock_o` to 0.
- R4: At a window close, an absolute count error of REGAIN_ERR or less drives `lock_o` to 1.
- R5: At a window close, an error greater than REGAIN_ERR but no greater than DROP_ERR leaves `lock_o` unchanged. An error of exactly DROP_ERR does not drop lock.
- R6: `lock_o` changes only in the cycles that follow a window close or a timeout, never in the middle of a window.
- R7: The internal select state takes on the lock value only after SEL_WINS consecutive verdicts (window closes or timeouts) that differ from it. A single verdict that agrees with it clears the run. `sel_o` is 1 for phase tracking and 0 for frequency acquisition.
- R8: While `acq_only_i` is 1, `sel_o` is 0 from the next cycle on. The select filter keeps running underneath, so on release `sel_o` shows the filtered state.
- R9: If no synchronized reference edge arrives for 2×WIN_REFS×RATIO recovered cycles, `lock_o` is forced to 0. The forcing repeats every such gap, and each repeat counts as one verdict for the select filter.
- R10: A recovered clock that is too slow and one that is too fast are judged on the same absolute error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock (divided view of the line rate); all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk`, nominally 1/RATIO of its rate |
| acq_only_i | input | 1 | 1 pins the select output to frequency acquisition |
| lock_o | output | 1 | Frequency-lock flag with hysteresis |
| sel_o | output | 1 | Detector select: 1 phase tracking, 0 frequency acquisition |

## Verification
The reference is generated as a sequence of 16-cycle periods with one period stretched or shortened by one cycle every M periods. This gives each window an exact signed error. Errors of zero, ±1, 2, 4, 8 and ±16 counts separate the regain bound (2 regains, 4 does not), the drop bound (8 holds, 16 drops) and the slow and fast directions. Runs of dropping windows broken by a single regaining one show that the select filter needs an unbroken run. Windows run with acquisition-only set show that select is pinned while the filter state keeps moving. A reference that stops shows the forced loss of lock at the gap limit and not before it.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    VERDICT_HOLD = 2'd0,
    VERDICT_GAIN = 2'd1,
    VERDICT_DROP = 2'd2
  } verdict_t;
endpackage

// File: rtl/flk_refsync.sv
module flk_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/flk_window.sv
module flk_window #(
  parameter int WIN_REFS = 16384,
  parameter int NOM      = 262144,
  parameter int CW       = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  output logic          done_o,
  output logic          tmo_o,
  output logic [CW-1:0] diff_o
);
  localparam int EW      = (WIN_REFS > 1) ? $clog2(WIN_REFS) : 1;
  localparam int GAP_LIM = 2 * NOM;
  localparam int GW      = $clog2(GAP_LIM + 1);

  logic          armed_q;
  logic [EW-1:0] edge_q;
  logic [CW-1:0] cyc_q;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] cyc_inc;
  logic [CW:0]   meas;
  logic [CW:0]   nom_w;
  logic [CW:0]   diff_w;

  always_comb begin
    cyc_inc = (cyc_q == {CW{1'b1}}) ? cyc_q : cyc_q + 1'b1;
    meas    = {1'b0, cyc_q} + 1'b1;
    nom_w   = (CW+1)'(NOM);
    diff_w  = (meas >= nom_w) ? (meas - nom_w) : (nom_w - meas);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      edge_q  <= '0;
      cyc_q   <= '0;
      gap_q   <= '0;
      done_o  <= 1'b0;
      tmo_o   <= 1'b0;
      diff_o  <= '0;
    end else begin
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
      if (rise_i) begin
        gap_q <= '0;
        if (!armed_q) begin
          armed_q <= 1'b1;
          edge_q  <= '0;
          cyc_q   <= '0;
        end else if (edge_q == EW'(WIN_REFS - 1)) begin
          done_o <= 1'b1;
          diff_o <= diff_w[CW-1:0];
          edge_q <= '0;
          cyc_q  <= '0;
        end else begin
          edge_q <= edge_q + 1'b1;
          cyc_q  <= cyc_inc;
        end
      end else if (gap_q == GW'(GAP_LIM - 1)) begin
        tmo_o   <= 1'b1;
        armed_q <= 1'b0;
        gap_q   <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
        if (armed_q) cyc_q <= cyc_inc;
      end
    end
  end
endmodule

// File: rtl/flk_hyst.sv
module flk_hyst
  import flk_pkg::*;
#(
  parameter int CW         = 20,
  parameter int DROP_ERR   = 524,
  parameter int REGAIN_ERR = 131
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done_i,
  input  logic          tmo_i,
  input  logic [CW-1:0] diff_i,
  output logic          lock_o,
  output logic          upd_o
);
  verdict_t verdict;

  always_comb begin
    if (tmo_i || diff_i > CW'(DROP_ERR))  verdict = VERDICT_DROP;
    else if (diff_i <= CW'(REGAIN_ERR))   verdict = VERDICT_GAIN;
    else                                  verdict = VERDICT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= done_i | tmo_i;
      if (done_i || tmo_i) begin
        case (verdict)
          VERDICT_DROP: lock_o <= 1'b0;
          VERDICT_GAIN: lock_o <= 1'b1;
          default:      lock_o <= lock_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/flk_selfilt.sv
module flk_selfilt #(
  parameter int SEL_WINS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  input  logic lock_i,
  input  logic acq_only_i,
  output logic state_o,
  output logic sel_o
);
  localparam int SW = $clog2(SEL_WINS + 1);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      state_o <= 1'b0;
      sel_o   <= 1'b0;
    end else begin
      sel_o <= state_o & ~acq_only_i;
      if (upd_i) begin
        if (lock_i == state_o) begin
          run_q <= '0;
        end else if (run_q == SW'(SEL_WINS - 1)) begin
          state_o <= lock_i;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int RATIO       = 16,
  parameter int WIN_REFS    = 16384,
  parameter int DROP_ERR    = 524,
  parameter int REGAIN_ERR  = 131,
  parameter int SEL_WINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  input  logic acq_only_i,
  output logic lock_o,
  output logic sel_o
);
  localparam int NOM = WIN_REFS * RATIO;
  localparam int CW  = $clog2(4 * NOM);

  logic          ref_rise;
  logic          win_done;
  logic          win_tmo;
  logic [CW-1:0] win_diff;
  logic          hyst_upd;
  logic          filt_state;

  flk_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_i(ref_clk_i), .rise_o(ref_rise)
  );

  flk_window #(.WIN_REFS(WIN_REFS), .NOM(NOM), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .rise_i(ref_rise),
    .done_o(win_done), .tmo_o(win_tmo), .diff_o(win_diff)
  );

  flk_hyst #(.CW(CW), .DROP_ERR(DROP_ERR), .REGAIN_ERR(REGAIN_ERR)) u_hyst (
    .clk(clk), .rst(rst), .done_i(win_done), .tmo_i(win_tmo),
    .diff_i(win_diff), .lock_o(lock_o), .upd_o(hyst_upd)
  );

  flk_selfilt #(.SEL_WINS(SEL_WINS)) u_filt (
    .clk(clk), .rst(rst), .upd_i(hyst_upd), .lock_i(lock_o),
    .acq_only_i(acq_only_i), .state_o(filt_state), .sel_o(sel_o)
  );
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int CW         = 20,
  parameter int DROP_ERR   = 524,
  parameter int REGAIN_ERR = 131
) (
  input logic          clk,
  input logic          rst,
  input logic          acq_only_i,
  input logic          lock_o,
  input logic          sel_o,
  input logic          win_done,
  input logic          win_tmo,
  input logic [CW-1:0] win_diff,
  input logic          filt_state
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!lock_o && !sel_o));

  p_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (win_done && win_diff > CW'(DROP_ERR)) |=> !lock_o);

  p_regain_r4: assert property (@(posedge clk) disable iff (rst)
    (win_done && !win_tmo && win_diff <= CW'(REGAIN_ERR)) |=> lock_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (win_done && !win_tmo && win_diff > CW'(REGAIN_ERR) && win_diff <= CW'(DROP_ERR))
      |=> $stable(lock_o));

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(win_done || win_tmo) |=> $stable(lock_o));

  p_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_state) |-> (filt_state == lock_o));

  p_pinned_r8: assert property (@(posedge clk) disable iff (rst)
    acq_only_i |=> !sel_o);

  p_starve_r9: assert property (@(posedge clk) disable iff (rst)
    win_tmo |=> !lock_o);
endmodule

bind freq_lock_detect flk_checker #(
  .CW(CW), .DROP_ERR(DROP_ERR), .REGAIN_ERR(REGAIN_ERR)
) u_chk (
  .clk(clk), .rst(rst), .acq_only_i(acq_only_i), .lock_o(lock_o),
  .sel_o(sel_o), .win_done(win_done), .win_tmo(win_tmo),
  .win_diff(win_diff), .filt_state(filt_state)
);

// File: tb/tb_freq_lock_detect.sv
module tb_freq_lock_detect;
  localparam int RATIO = 16;
  localparam int WIN   = 256;
  localparam int DROP  = 8;
  localparam int REGN  = 2;
  localparam int SWINS = 4;
  localparam int NOM   = WIN * RATIO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_i = 1'b0;
  logic acq = 1'b0;
  logic lock, sel;

  freq_lock_detect #(
    .RATIO(RATIO), .WIN_REFS(WIN), .DROP_ERR(DROP), .REGAIN_ERR(REGN),
    .SEL_WINS(SWINS), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .ref_clk_i(ref_i), .acq_only_i(acq),
    .lock_o(lock), .sel_o(sel)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    win;
    logic  lock;
    logic  sel;
    string lreq;
    string sreq;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  bit   has_pend = 1'b0;
  bit   m_lock = 1'b0;
  bit   m_state = 1'b0;
  int   m_run = 0;
  int   widx = 0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: one window of WIN reference periods, every m-th period
  // lengthened by delta cycles (m = 0: all periods nominal).
  task automatic run_window(input int m, input int delta, input bit acq_v,
                            input string lreq, input string sreq);
    int err;
    err = (m > 0) ? (WIN / m) * delta : 0;
    if (err < 0) err = -err;
    for (int i = 0; i < WIN; i++) begin
      int len;
      len = RATIO + ((m > 0 && ((i + 1) % m) == 0) ? delta : 0);
      ref_i = 1'b1;
      if (i == 0 && has_pend) begin
        q.push_back(pend);
        has_pend = 1'b0;
      end
      if (i == 100) acq = acq_v;
      if (i == 128) begin
        // R6: mid-window the flag still shows the previous verdict
        check("R6", "lock mid-window", lock, m_lock);
      end
      cyc(8);
      ref_i = 1'b0;
      cyc(len - 8);
    end
    if (err > DROP) m_lock = 1'b0;
    else if (err <= REGN) m_lock = 1'b1;
    if (m_lock == m_state) m_run = 0;
    else if (m_run == SWINS - 1) begin
      m_state = m_lock;
      m_run = 0;
    end else m_run++;
    pend = '{widx, m_lock, m_state & ~acq_v, lreq, sreq};
    has_pend = 1'b1;
    widx++;
  endtask

  task automatic close_window();
    ref_i = 1'b1;
    if (has_pend) begin
      q.push_back(pend);
      has_pend = 1'b0;
    end
    cyc(8);
    ref_i = 1'b0;
  endtask

  // Monitor: scoreboard pop, sampled well after the verdict settles
  initial begin
    forever begin
      exp_t e;
      while (q.size() == 0) @(negedge clk);
      cyc(40);
      e = q.pop_front();
      check(e.lreq, $sformatf("lock after window %0d", e.win), lock, e.lock);
      check(e.sreq, $sformatf("sel after window %0d", e.win), sel, e.sel);
    end
  end

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(4);
    // R1: outputs low in reset
    check("R1", "lock in reset", lock, 1'b0);
    check("R1", "sel in reset", sel, 1'b0);
    rst = 1'b0;
    cyc(2);
    check("R1", "lock after reset", lock, 1'b0);
    check("R1", "sel after reset", sel, 1'b0);

    run_window(0, 0, 1'b0, "R4", "R7");    // exact count: regain
    run_window(0, 0, 1'b0, "R2", "R7");
    run_window(0, 0, 1'b0, "R2", "R7");
    run_window(0, 0, 1'b0, "R2", "R7");    // fourth agreeing verdict: sel up
    run_window(64, 1, 1'b0, "R5", "R7");   // err 4: hold high
    run_window(16, 1, 1'b0, "R3", "R7");   // err 16 fast: drop
    run_window(64, 1, 1'b0, "R5", "R7");   // err 4: hold low
    run_window(16, -1, 1'b0, "R10", "R7"); // err 16 slow: stays dropped
    run_window(256, 1, 1'b0, "R4", "R7");  // err 1: regain, breaks the run
    run_window(16, 1, 1'b0, "R3", "R7");
    run_window(16, -1, 1'b0, "R10", "R7");
    run_window(16, 1, 1'b0, "R3", "R7");
    run_window(16, 1, 1'b0, "R3", "R7");   // fourth in a row: sel down
    run_window(32, 1, 1'b0, "R5", "R7");   // err 8 while low: hold
    run_window(128, -1, 1'b0, "R4", "R7"); // err 2: regain boundary
    run_window(32, 1, 1'b0, "R5", "R7");   // err 8 while high: no drop
    run_window(0, 0, 1'b1, "R4", "R8");
    run_window(0, 0, 1'b1, "R4", "R8");    // filter state rises underneath
    run_window(0, 0, 1'b1, "R4", "R8");
    run_window(0, 0, 1'b0, "R4", "R8");    // released: sel shows state
    close_window();

    // R9: reference stops; lock held until the gap limit, then forced low
    cyc(2 * NOM - 100);
    check("R9", "lock before gap limit", lock, 1'b1);
    cyc(200);
    check("R9", "lock after gap limit", lock, 1'b0);
    while (q.size() != 0) cyc(1);
    cyc(50);
    finish_run();
  end
endmodule